// File: doc/BRIEF.md
# Selectable Trigger Detector with Event Pre-divider

This block picks one line out of a wide vector of asynchronous event sources, brings it into the local clock domain, and looks for a trigger condition on it. The condition can be a level (active high or active low) or an edge (rising, falling or either). Software chooses the condition, the source line, an optional event pre-divider and the shape of the output through a single 32-bit configuration word. The word is loaded with a write strobe and can be read back.

Detected events go to the pre-divider. When it is enabled, it lets one trigger through for every N detected events. When it is disabled, every event goes through. Each trigger that gets through raises a status bit for one cycle. The downstream trigger output is either that same one-cycle pulse, or a level that flips once per passed trigger. Counting and interrupt generation belong to the logic that consumes the trigger.

The block has no data stream. Every pin is a plain control or status signal, so there is no valid/ready handshake and no back-pressure.

Top module: `evt_trigger_unit`

## Requirements
- R1: Configuration bits 13..8 hold a 6-bit index that selects the source line from `src_i`. Activity on any other line has no effect on `trig_o` or `status_o`.
- R2: Detect mode lives in bits 3..1. With code 000, a trigger event occurs in every cycle in which the synchronised source is 1. With code 001, it occurs in every cycle in which the synchronised source is 0.
- R3: Detect code 100 gives one event per 0-to-1 transition of the synchronised source. Code 101 gives one event per 1-to-0 transition. Code 110 gives one event per transition in either direction.
- R4: Detect codes 010, 011 and 111 never produce an event, whatever the source does.
- R5: Bit 7 enables the pre-divider and bits 23..16 hold its count N. When the pre-divider is enabled, only every N-th detected event is passed on. When it is disabled, every detected event is passed on.
- R6: When the pre-divider is enabled, a count of 0 behaves exactly like a count of 1.
- R7: Output mode lives in bits 5..4. With code 01, `trig_o` flips once for each passed trigger. With any other code, `trig_o` is high for exactly the cycles in which a trigger is passed.
- R8: `cfg_rdata_o` returns the writable fields at their write positions (23..16, 13..8, 7, 5..4, 3..1) and returns 0 in bits 31..24, 15..14 and 6. After reset, every field is zero and both outputs are low.
- R9: Each write of the configuration word clears the pre-divider's event count, so that the next trigger needs N fresh events.
- R10: `status_o`, mirrored in `cfg_rdata_o` bit 0, is high for exactly one cycle per passed trigger. A source change applied before clock edge k shows on `trig_o` and `status_o` after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Asynchronous event source lines |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration word to write |
| cfg_rdata_o | output | 32 | Configuration readback, with status in bit 0 |
| trig_o | output | 1 | Trigger output (pulse or toggle) |
| status_o | output | 1 | High in each cycle a trigger is passed |

## Verification
A source value driven before edge k affects the outputs after edge k+2. That delay is two synchroniser flops plus the registered output stage; the edge detector's history flop adds no delay. A configuration write is visible on `cfg_rdata_o` one edge after the strobe.

The driver predicts each cycle's trigger, status and bit-0 readback from the requirements. It queues that prediction tagged with the cycle in which it falls due (the current count plus three). The monitor compares the queued item only in that cycle, on the falling edge.

Reconfiguration happens only while the source is held at a non-triggering idle value. The word is written twice, so that no prediction spans a change of source or mode.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int CFG_W   = 32;
  localparam int PRE_W   = 8;
  localparam int SEL_W   = 6;
  localparam int PRE_LSB = 16;
  localparam int SEL_LSB = 8;
  localparam int PEN_POS = 7;
  localparam int OM_LSB  = 4;
  localparam int DM_LSB  = 1;

  localparam logic [2:0] DM_HIGH = 3'b000;
  localparam logic [2:0] DM_LOW  = 3'b001;
  localparam logic [2:0] DM_RISE = 3'b100;
  localparam logic [2:0] DM_FALL = 3'b101;
  localparam logic [2:0] DM_BOTH = 3'b110;

  localparam logic [1:0] OM_TOGGLE = 2'b01;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [SEL_W-1:0] sel;
    logic             pen;
    logic [1:0]       omode;
    logic [2:0]       dmode;
  } trig_cfg_t;

  function automatic trig_cfg_t cfg_unpack(input logic [CFG_W-1:0] w);
    trig_cfg_t c;
    c.pre   = w[PRE_LSB +: PRE_W];
    c.sel   = w[SEL_LSB +: SEL_W];
    c.pen   = w[PEN_POS];
    c.omode = w[OM_LSB +: 2];
    c.dmode = w[DM_LSB +: 3];
    return c;
  endfunction

  function automatic logic [CFG_W-1:0] cfg_pack(input trig_cfg_t c);
    logic [CFG_W-1:0] w;
    w = '0;
    w[PRE_LSB +: PRE_W] = c.pre;
    w[SEL_LSB +: SEL_W] = c.sel;
    w[PEN_POS]          = c.pen;
    w[OM_LSB +: 2]      = c.omode;
    w[DM_LSB +: 3]      = c.dmode;
    return w;
  endfunction

  function automatic logic dmode_listed(input logic [2:0] m);
    return (m == DM_HIGH) || (m == DM_LOW) || (m == DM_RISE) ||
           (m == DM_FALL) || (m == DM_BOTH);
  endfunction
endpackage

// File: rtl/trig_cfg_reg.sv
module trig_cfg_reg
  import trig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output trig_cfg_t        cfg_o,
  output logic [CFG_W-1:0] rb_o
);
  trig_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (we_i) cfg_q <= cfg_unpack(wdata_i);
  end

  assign cfg_o = cfg_q;
  assign rb_o  = cfg_pack(cfg_q);
endmodule

// File: rtl/trig_src_detect.sv
module trig_src_detect
  import trig_pkg::*;
#(
  parameter int N_SRC       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [2:0]       dmode_i,
  output logic             evt_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic                   pick;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   cur;
  logic                   prev_q;

  always_comb begin
    pick = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (sel_i == SEL_W'(i)) pick = src_i[i];
    end
  end

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pick;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pick};
      end
    end
  endgenerate

  assign cur = sync_q[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;
  end

  always_comb begin
    unique case (dmode_i)
      DM_HIGH: evt_o = cur;
      DM_LOW:  evt_o = ~cur;
      DM_RISE: evt_o = cur & ~prev_q;
      DM_FALL: evt_o = ~cur & prev_q;
      DM_BOTH: evt_o = cur ^ prev_q;
      default: evt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/trig_prediv.sv
module trig_prediv #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [PRE_W-1:0] lim_i,
  input  logic             evt_i,
  output logic             pass_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] lim_eff;
  logic             hit;

  assign lim_eff = (lim_i == '0) ? PRE_W'(1) : lim_i;
  assign hit     = evt_i && (cnt_q == lim_eff - PRE_W'(1));
  assign pass_o  = en_i ? hit : evt_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (en_i && evt_i)  cnt_q <= hit ? '0 : cnt_q + PRE_W'(1);
  end

  // R5: with the divider enabled, the event count stays below the effective limit
  assert_cnt_below_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> (cnt_q < lim_eff));

  // R9: a configuration write leaves the count at zero
  assert_cnt_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/trig_out_stage.sv
module trig_out_stage
  import trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pass_i,
  input  logic [1:0] omode_i,
  output logic       trig_o,
  output logic       status_o
);
  logic pass_q;
  logic tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      pass_q <= pass_i;
      tog_q  <= tog_q ^ pass_i;
    end
  end

  assign status_o = pass_q;
  assign trig_o   = (omode_i == OM_TOGGLE) ? tog_q : pass_q;

  // R7: each passed trigger flips the toggle state
  assert_toggle_flips_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pass_i |=> (tog_q != $past(tog_q)));

  // R7: with no passed trigger the toggle state holds
  assert_toggle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pass_i |=> $stable(tog_q));
endmodule

// File: rtl/evt_trigger_unit.sv
module evt_trigger_unit
  import trig_pkg::*;
#(
  parameter int N_SRC       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             cfg_we_i,
  input  logic [31:0]      cfg_wdata_i,
  output logic [31:0]      cfg_rdata_o,
  output logic             trig_o,
  output logic             status_o
);
  trig_cfg_t        cfg;
  logic [CFG_W-1:0] rb;
  logic             evt;
  logic             pass;

  trig_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg),
    .rb_o    (rb)
  );

  trig_src_detect #(.N_SRC(N_SRC), .SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_i   (src_i),
    .sel_i   (cfg.sel),
    .dmode_i (cfg.dmode),
    .evt_o   (evt)
  );

  trig_prediv #(.PRE_W(PRE_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (cfg_we_i),
    .en_i   (cfg.pen),
    .lim_i  (cfg.pre),
    .evt_i  (evt),
    .pass_o (pass)
  );

  trig_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .pass_i   (pass),
    .omode_i  (cfg.omode),
    .trig_o   (trig_o),
    .status_o (status_o)
  );

  assign cfg_rdata_o = {rb[31:1], status_o};

  // R4: an unlisted detect code in force in the previous cycle yields no status
  assert_unlisted_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dmode_listed($past(cfg.dmode)) |-> !status_o);

  // R10: status and readback bit 0 agree at every edge
  assert_status_mirror_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata_o[0] == status_o);
endmodule

// File: tb/evt_trigger_unit_bench.sv
`timescale 1ns/1ps
module evt_trigger_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        trig;
  logic        stat;

  always #2.5 clk = ~clk;

  evt_trigger_unit u_evt_trigger_unit (
    .clk (clk), .rst_n (rst_n), .src_i (src), .cfg_we_i (we),
    .cfg_wdata_i (wdata), .cfg_rdata_o (rdata), .trig_o (trig), .status_o (stat)
  );

  typedef struct { int due; bit trig; bit stat; string req; } exp_t;
  exp_t q[$];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit ended = 0;

  logic [31:0] mcfg = '0;
  bit          xprev = 0;
  int          mcnt = 0;
  bit          mtog = 0;

  always @(posedge clk) cyc++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h cycle=%0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [31:0] mk(input int sel, input logic [2:0] dm,
                                     input logic [1:0] om, input bit pen, input int pre);
    return {8'h00, 8'(pre), 2'b00, 6'(sel), pen, 1'b0, om, dm, 1'b0};
  endfunction

  // scoreboard monitor: compares each queued item in the cycle it falls due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      if (e.due < cyc) begin
        checks++; errors++;
        $display("FAIL %s actual=missed expected=due_%0d cycle=%0d", e.req, e.due, cyc);
      end else begin
        chk({e.req, " trig"}, {31'b0, trig}, {31'b0, e.trig});
        chk({e.req, " status R10"}, {31'b0, stat}, {31'b0, e.stat});
        chk({e.req, " rdata0 R10"}, {31'b0, rdata[0]}, {31'b0, e.stat});
      end
    end
  end

  // driver: apply one source value and queue the prediction for it
  task automatic step(input logic [63:0] v, input string req);
    bit cur, ev, pass;
    int lim;
    exp_t e;
    @(negedge clk);
    src = v;
    cur = v[mcfg[13:8]];
    case (mcfg[3:1])
      3'b000: ev = cur;
      3'b001: ev = !cur;
      3'b100: ev = cur && !xprev;
      3'b101: ev = !cur && xprev;
      3'b110: ev = cur != xprev;
      default: ev = 0;
    endcase
    xprev = cur;
    pass = ev;
    if (mcfg[7]) begin
      lim = (mcfg[23:16] == 0) ? 1 : int'(mcfg[23:16]);
      pass = 0;
      if (ev) begin
        if (mcnt + 1 >= lim) begin pass = 1; mcnt = 0; end
        else mcnt++;
      end
    end
    mtog ^= pass;
    e.due = cyc + 3;
    e.stat = pass;
    e.trig = (mcfg[5:4] == 2'b01) ? mtog : pass;
    e.req = req;
    q.push_back(e);
  endtask

  task automatic hold(input int n, input logic [63:0] v);
    for (int i = 0; i < n; i++) begin @(negedge clk); src = v; end
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk); we = 1; wdata = w;
    @(negedge clk); we = 0;
  endtask

  // reconfigure while the source sits at a non-triggering idle value
  task automatic configure(input logic [31:0] w, input logic [63:0] idle);
    hold(3, idle);
    wr(w);
    chk("R8 readback", {rdata[31:1], 1'b0}, w & 32'h00FF3FBE);
    hold(4, idle);
    wr(w);
    hold(4, idle);
    mcfg = w; mcnt = 0; xprev = idle[w[13:8]];
    mtog = trig;
  endtask

  task automatic run_rand(input int n, input string req);
    for (int i = 0; i < n; i++) step({$urandom(), $urandom()}, req);
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done cycle=%0d", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset rdata", rdata, 32'h0);
    chk("R8 reset trig", {31'b0, trig}, 32'h0);
    chk("R8 reset status", {31'b0, stat}, 32'h0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // reserved bits zero; mode 111 unlisted
    configure(32'hFFFF_FFFF, '0);
    chk("R8 status idle", {31'b0, rdata[0]}, 32'h0);
    run_rand(30, "R4 mode111");
    configure(mk(5, 3'b010, 2'b00, 0, 0), '0);
    run_rand(30, "R4 mode010");
    configure(mk(9, 3'b011, 2'b00, 0, 0), '0);
    run_rand(30, "R4 mode011");

    configure(mk(5, 3'b000, 2'b00, 0, 0), '0);
    run_rand(40, "R2 high");
    // selected line held low while every other line is high
    for (int i = 0; i < 10; i++) step(~(64'h1 << 5), "R1 others ignored");
    configure(mk(63, 3'b001, 2'b00, 0, 0), {64{1'b1}});
    run_rand(40, "R2 low");
    for (int i = 0; i < 10; i++) step(64'h8000_0000_0000_0000, "R1 others ignored");

    configure(mk(37, 3'b100, 2'b00, 0, 0), '0);
    run_rand(40, "R3 rise");
    configure(mk(0, 3'b101, 2'b00, 0, 0), '0);
    run_rand(40, "R3 fall");
    configure(mk(12, 3'b110, 2'b00, 0, 0), '0);
    run_rand(40, "R3 both");

    configure(mk(20, 3'b100, 2'b00, 1, 3), '0);
    run_rand(60, "R5 divide3");
    configure(mk(20, 3'b110, 2'b00, 0, 5), '0);
    run_rand(40, "R5 disabled");
    configure(mk(3, 3'b100, 2'b00, 1, 0), '0);
    run_rand(40, "R6 zero count");

    // two edges, then rewrite: next trigger needs three fresh edges
    configure(mk(2, 3'b100, 2'b00, 1, 3), '0);
    for (int i = 0; i < 2; i++) begin step(64'h4, "R9 pre"); step(64'h0, "R9 pre"); end
    configure(mk(2, 3'b100, 2'b00, 1, 3), '0);
    for (int i = 0; i < 3; i++) begin step(64'h4, "R9 fresh"); step(64'h0, "R9 fresh"); end

    configure(mk(44, 3'b100, 2'b01, 1, 2), '0);
    run_rand(60, "R7 toggle");
    configure(mk(44, 3'b000, 2'b10, 0, 0), '0);
    run_rand(30, "R7 mode10");

    hold(5, '0);
    finish_run();
  end
endmodule